// File: doc/BRIEF.md
# Receive Frame DMA Buffer Manager

This block takes received network frames from a word stream and stores them one 32-bit word at a time in a circular host buffer of 16 KB. Each stored frame begins with a status word, followed by a length word and then the payload words. The next frame begins at the following 32-bit boundary, so when a frame length is not a multiple of four the unused bytes of its last word are left as a gap.

A host tracks stored frames through a small register port. Reads of the frame-count register alternate between two phases. A read in the first phase reports the frames stored so far and commits the space they hold, so the writer cannot reuse it. The next read releases that space again. Frames keep arriving and being counted while earlier frames are committed, so a host empties the buffer by reading the count until it reads zero. When a frame is stored, an event flag is set, and an interrupt follows if it is enabled. A frame that does not fit in the space that is neither counted nor committed is dropped whole.

Top module: `rxdma_buf_mgr`

## Requirements
- R1: A stored frame that starts at byte offset S has its status word at S, its length in bytes at S+4, and payload word i at S+8+4i. All offsets wrap modulo 16384, and the memory word address is the byte offset divided by four.
- R2: The frame that follows starts at S + 8 + (length rounded up to a multiple of 4), modulo 16384.
- R3: In the commit phase (the phase after reset), a read of register select 0 returns the number of frames stored since the last commit. The read commits their bytes, sets the count to zero and switches to the release phase.
- R4: In the release phase, a read of select 0 returns the current count without clearing it, releases the committed bytes and returns to the commit phase.
- R5: A frame is accepted only when 8 + its rounded-up length is no more than 16384 minus the counted bytes minus the committed bytes. A rejected frame causes no memory write, leaves the write position unchanged and sets overrun bit 9 of the event register (select 1).
- R6: Storing a frame sets event bit 7. The `irq` output equals event bit 7 AND bit 7 of the configuration register (select 2, written with `reg_wr`, read back whole).
- R7: A read of the event register returns bits 7 and 9 and clears both. A new event in the same cycle as the read remains set.
- R8: Select 3 returns the start offset of the most recently stored frame. Select 4 returns the current write byte offset, which is the start of the next frame when no frame is in progress.
- R9: After reset the count is zero, the phase is commit, the whole buffer is free, the start and write offsets are zero, the event flags and configuration are zero and `in_ready` is high.
- R10: After the last beat of an accepted frame, `in_ready` is low for exactly two cycles while the status and length words are written, one word per cycle. During a dropped frame `in_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream beat valid |
| in_sof | input | 1 | First beat of a frame; `in_len` is valid with it |
| in_last | input | 1 | Last beat of a frame; `in_status` is valid with it |
| in_len | input | 16 | Frame length in bytes |
| in_status | input | 32 | Receive status word for the frame |
| in_data | input | 32 | Payload word |
| in_ready | output | 1 | Stream can accept a beat |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 12 | Buffer word address |
| mem_wdata | output | 32 | Buffer write data |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 3 | Register select: 0 count, 1 event, 2 config, 3 frame start, 4 write offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the strobe cycle |
| irq | output | 1 | Frame-stored interrupt |

## Verification
The assertions check on every cycle that the counted and committed bytes together never exceed the buffer size. They also check that a completed frame is always followed by the event flag, that each count read has its phase effect on the count, and that a stalled input always pairs with a header write for exactly two cycles. The memory image can only be shown by the bench scenarios. A length sweep checks the word layout and the alignment gaps, a fill to capacity checks dropping and the exact-fit boundary, and a frame that crosses the end of the buffer checks wrap-around. Only these scenarios show that committed space is protected until the release read.

// File: rtl/rxdma_pkg.sv
`timescale 1ns/1ps
package rxdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BODY, ST_DROP, ST_STAT, ST_LENW
  } wr_state_t;

  typedef enum logic [2:0] {
    RSEL_COUNT = 3'd0,
    RSEL_EVENT = 3'd1,
    RSEL_CFG   = 3'd2,
    RSEL_SOF   = 3'd3,
    RSEL_POS   = 3'd4
  } reg_sel_t;

  localparam int EVT_FRAME_BIT = 7;
  localparam int EVT_OVR_BIT   = 9;
  localparam int CFG_IRQ_BIT   = 7;
endpackage

// File: rtl/rxdma_wr_path.sv
`timescale 1ns/1ps
module rxdma_wr_path
  import rxdma_pkg::*;
#(
  parameter int AW    = 14,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_last,
  input  logic [LEN_W-1:0] in_len,
  input  logic [31:0]      in_status,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  input  logic [AW:0]      free_bytes,
  output logic             mem_we,
  output logic [AW-3:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             done,
  output logic [AW:0]      done_bytes,
  output logic             overrun,
  output logic [AW-1:0]    sof_off,
  output logic [AW-1:0]    pos
);
  localparam int NW = LEN_W + 2;
  localparam logic [NW-1:0] RND_MASK = {{LEN_W{1'b1}}, 2'b00};
  localparam logic [AW-3:0] W1 = (AW-2)'(1);
  localparam logic [AW-3:0] W2 = (AW-2)'(2);
  localparam logic [AW-1:0] B4 = AW'(4);
  localparam logic [AW-1:0] B8 = AW'(8);
  localparam logic [AW-1:0] B12 = AW'(12);

  wr_state_t        st_q, st_n;
  logic [AW-1:0]    start_q, start_n, wptr_q, wptr_n, sof_q, sof_n;
  logic [LEN_W-1:0] left_q, left_n, len_q, len_n;
  logic [AW:0]      need_q, need_n;
  logic [31:0]      stat_q, stat_n;

  logic [NW-1:0]    need;
  logic [LEN_W-1:0] words;
  logic             fits;

  assign need  = (((NW)'(in_len) + (NW)'(3)) & RND_MASK) + (NW)'(8);
  assign words = need[NW-1:2] - LEN_W'(2);
  assign fits  = need <= (NW)'(free_bytes);

  always_comb begin
    st_n = st_q; start_n = start_q; wptr_n = wptr_q; sof_n = sof_q;
    left_n = left_q; len_n = len_q; need_n = need_q; stat_n = stat_q;
    in_ready  = (st_q == ST_IDLE) || (st_q == ST_BODY) || (st_q == ST_DROP);
    mem_we    = 1'b0;
    mem_addr  = wptr_q[AW-1:2];
    mem_wdata = in_data;
    done      = 1'b0;
    overrun   = 1'b0;
    case (st_q)
      ST_IDLE: if (in_valid && in_sof) begin
        if (fits) begin
          start_n = wptr_q;
          len_n   = in_len;
          need_n  = need[AW:0];
          if (words != '0) begin
            mem_we   = 1'b1;
            mem_addr = wptr_q[AW-1:2] + W2;
            left_n   = words - LEN_W'(1);
            wptr_n   = wptr_q + B12;
          end else begin
            left_n = '0;
            wptr_n = wptr_q + B8;
          end
          if (in_last) begin
            stat_n = in_status;
            st_n   = ST_STAT;
          end else begin
            st_n = ST_BODY;
          end
        end else begin
          overrun = 1'b1;
          st_n    = in_last ? ST_IDLE : ST_DROP;
        end
      end
      ST_BODY: if (in_valid) begin
        if (left_q != '0) begin
          mem_we = 1'b1;
          wptr_n = wptr_q + B4;
          left_n = left_q - LEN_W'(1);
        end
        if (in_last) begin
          stat_n = in_status;
          st_n   = ST_STAT;
        end
      end
      ST_DROP: if (in_valid && in_last) st_n = ST_IDLE;
      ST_STAT: begin
        mem_we    = 1'b1;
        mem_addr  = start_q[AW-1:2];
        mem_wdata = stat_q;
        st_n      = ST_LENW;
      end
      ST_LENW: begin
        mem_we    = 1'b1;
        mem_addr  = start_q[AW-1:2] + W1;
        mem_wdata = 32'(len_q);
        done      = 1'b1;
        wptr_n    = start_q + need_q[AW-1:0];
        sof_n     = start_q;
        st_n      = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; start_q <= '0; wptr_q <= '0; sof_q <= '0;
      left_q <= '0; len_q <= '0; need_q <= '0; stat_q <= '0;
    end else begin
      st_q <= st_n; start_q <= start_n; wptr_q <= wptr_n; sof_q <= sof_n;
      left_q <= left_n; len_q <= len_n; need_q <= need_n; stat_q <= stat_n;
    end
  end

  assign done_bytes = need_q;
  assign sof_off    = sof_q;
  assign pos        = wptr_q;
endmodule

// File: rtl/rxdma_ledger.sv
`timescale 1ns/1ps
module rxdma_ledger #(
  parameter int AW    = 14,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [AW:0]      done_bytes,
  input  logic             cnt_rd,
  output logic [AW:0]      free_bytes,
  output logic [AW+1:0]    used_bytes,
  output logic [CNT_W-1:0] frame_cnt,
  output logic             phase_free
);
  localparam logic [AW:0] SIZE = (AW+1)'(1) << AW;

  logic [AW:0]      pend_q, pend_n, comm_q, comm_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             ph_q, ph_n;

  always_comb begin
    pend_n = pend_q; comm_n = comm_q; cnt_n = cnt_q; ph_n = ph_q;
    if (cnt_rd) begin
      if (!ph_q) begin
        comm_n = pend_q;
        pend_n = '0;
        cnt_n  = '0;
        ph_n   = 1'b1;
      end else begin
        comm_n = '0;
        ph_n   = 1'b0;
      end
    end
    if (done) begin
      pend_n = pend_n + done_bytes;
      cnt_n  = cnt_n + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0; comm_q <= '0; cnt_q <= '0; ph_q <= 1'b0;
    end else begin
      pend_q <= pend_n; comm_q <= comm_n; cnt_q <= cnt_n; ph_q <= ph_n;
    end
  end

  assign used_bytes = {1'b0, pend_q} + {1'b0, comm_q};
  assign free_bytes = SIZE - used_bytes[AW:0];
  assign frame_cnt  = cnt_q;
  assign phase_free = ph_q;
endmodule

// File: rtl/rxdma_events.sv
`timescale 1ns/1ps
module rxdma_events
  import rxdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  logic        overrun,
  input  logic        evt_rd,
  input  logic        cfg_wr,
  input  logic [15:0] cfg_wdata,
  output logic        evt_frame,
  output logic        evt_ovr,
  output logic [15:0] cfg,
  output logic        irq
);
  logic        fr_q, fr_n, ov_q, ov_n;
  logic [15:0] cfg_q, cfg_n;

  always_comb begin
    fr_n  = evt_rd ? 1'b0 : fr_q;
    ov_n  = evt_rd ? 1'b0 : ov_q;
    if (done)    fr_n = 1'b1;
    if (overrun) ov_n = 1'b1;
    cfg_n = cfg_wr ? cfg_wdata : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0; ov_q <= 1'b0; cfg_q <= '0;
    end else begin
      fr_q <= fr_n; ov_q <= ov_n; cfg_q <= cfg_n;
    end
  end

  assign evt_frame = fr_q;
  assign evt_ovr   = ov_q;
  assign cfg       = cfg_q;
  assign irq       = fr_q & cfg_q[CFG_IRQ_BIT];
endmodule

// File: rtl/rxdma_buf_mgr.sv
`timescale 1ns/1ps
module rxdma_buf_mgr
  import rxdma_pkg::*;
#(
  parameter int AW    = 14,
  parameter int LEN_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_last,
  input  logic [LEN_W-1:0] in_len,
  input  logic [31:0]      in_status,
  input  logic [31:0]      in_data,
  output logic             in_ready,
  output logic             mem_we,
  output logic [AW-3:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             reg_rd,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  output logic             irq
);
  logic [1:0]       rst_q;
  logic             rst_i;
  logic             frame_done, overrun, cnt_rd, evt_rd, cfg_wr;
  logic             evt_frame, evt_ovr, phase_free;
  logic [AW:0]      free_bytes, done_bytes;
  logic [AW+1:0]    used_bytes;
  logic [CNT_W-1:0] frame_cnt;
  logic [AW-1:0]    sof_off, pos;
  logic [15:0]      cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i = rst_q[1];

  assign cnt_rd = reg_rd && (reg_sel_t'(reg_sel) == RSEL_COUNT);
  assign evt_rd = reg_rd && (reg_sel_t'(reg_sel) == RSEL_EVENT);
  assign cfg_wr = reg_wr && (reg_sel_t'(reg_sel) == RSEL_CFG);

  rxdma_wr_path #(.AW(AW), .LEN_W(LEN_W)) u_wr (
    .clk(clk), .rst_n(rst_i),
    .in_valid(in_valid), .in_sof(in_sof), .in_last(in_last),
    .in_len(in_len), .in_status(in_status), .in_data(in_data),
    .in_ready(in_ready), .free_bytes(free_bytes),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .done(frame_done), .done_bytes(done_bytes), .overrun(overrun),
    .sof_off(sof_off), .pos(pos)
  );

  rxdma_ledger #(.AW(AW), .CNT_W(CNT_W)) u_led (
    .clk(clk), .rst_n(rst_i), .done(frame_done), .done_bytes(done_bytes),
    .cnt_rd(cnt_rd), .free_bytes(free_bytes), .used_bytes(used_bytes),
    .frame_cnt(frame_cnt), .phase_free(phase_free)
  );

  rxdma_events u_evt (
    .clk(clk), .rst_n(rst_i), .done(frame_done), .overrun(overrun),
    .evt_rd(evt_rd), .cfg_wr(cfg_wr), .cfg_wdata(reg_wdata),
    .evt_frame(evt_frame), .evt_ovr(evt_ovr), .cfg(cfg), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel_t'(reg_sel))
      RSEL_COUNT: reg_rdata = 16'(frame_cnt);
      RSEL_EVENT: begin
        reg_rdata[EVT_FRAME_BIT] = evt_frame;
        reg_rdata[EVT_OVR_BIT]   = evt_ovr;
      end
      RSEL_CFG:   reg_rdata = cfg;
      RSEL_SOF:   reg_rdata = 16'(sof_off);
      RSEL_POS:   reg_rdata = 16'(pos);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxdma_chk.sv
`timescale 1ns/1ps
module rxdma_chk #(
  parameter int AW    = 14,
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_i,
  input logic             frame_done,
  input logic             evt_frame,
  input logic             cnt_rd,
  input logic             phase_free,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [AW+1:0]    used_bytes,
  input logic             in_ready,
  input logic             mem_we
);
  localparam logic [AW+1:0] SIZE = (AW+2)'(1) << AW;

  // R5: counted plus committed space never exceeds the buffer
  a_r5_no_overcommit: assert property (@(posedge clk) disable iff (!rst_i)
    used_bytes <= SIZE);

  // R6: a stored frame always raises the event flag
  a_r6_event_on_done: assert property (@(posedge clk) disable iff (!rst_i)
    frame_done |=> evt_frame);

  // R3: commit-phase read clears the count and enters the release phase
  a_r3_commit_read: assert property (@(posedge clk) disable iff (!rst_i)
    (cnt_rd && !phase_free && !frame_done) |=> (frame_cnt == '0) && phase_free);

  // R4: release-phase read keeps the count and returns to commit phase
  a_r4_release_read: assert property (@(posedge clk) disable iff (!rst_i)
    (cnt_rd && phase_free && !frame_done) |=> (frame_cnt == $past(frame_cnt)) && !phase_free);

  // R10: every stalled cycle writes a header word
  a_r10_stall_writes: assert property (@(posedge clk) disable iff (!rst_i)
    !in_ready |-> mem_we);

  // R10: a stall lasts at least two cycles
  a_r10_stall_min: assert property (@(posedge clk) disable iff (!rst_i)
    $fell(in_ready) |=> !in_ready);

  // R10: a stall lasts at most two cycles
  a_r10_stall_max: assert property (@(posedge clk) disable iff (!rst_i)
    (!in_ready && $past(!in_ready)) |=> in_ready);
endmodule

bind rxdma_buf_mgr rxdma_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_i(rst_i), .frame_done(frame_done), .evt_frame(evt_frame),
  .cnt_rd(cnt_rd), .phase_free(phase_free), .frame_cnt(frame_cnt),
  .used_bytes(used_bytes), .in_ready(in_ready), .mem_we(mem_we)
);

// File: tb/sim_rxdma_buf_mgr.sv
`timescale 1ns/1ps
module sim_rxdma_buf_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int BUF = 16384;

  logic        clk, rst_n;
  logic        in_valid, in_sof, in_last, in_ready;
  logic [15:0] in_len;
  logic [31:0] in_status, in_data;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        reg_rd, reg_wr;
  logic [2:0]  reg_sel;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq;

  int n_chk, n_err, we_cnt, exp_pos;
  logic finished;
  logic [31:0] bmem [0:4095];

  rxdma_buf_mgr u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_last(in_last), .in_len(in_len), .in_status(in_status),
    .in_data(in_data), .in_ready(in_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) begin
    if (mem_we) begin
      bmem[mem_addr] <= mem_wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  function automatic logic [31:0] pat(input int id, input int i);
    return 32'hC0DE0000 ^ 32'(id << 12) ^ 32'(i);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] sel, output logic [15:0] v);
    @(negedge clk); reg_sel = sel; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [15:0] v);
    @(negedge clk); reg_sel = sel; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic send(input int id, input int len, input logic [31:0] st,
                      output logic r0, output logic r1, output logic r2);
    int beats;
    beats = (len == 0) ? 1 : (len + 3) / 4;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (b == 0); in_last = (b == beats - 1);
      in_len = 16'(len); in_status = st; in_data = pat(id, b);
    end
    @(negedge clk); in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0; r0 = in_ready;
    @(negedge clk); r1 = in_ready;
    @(negedge clk); r2 = in_ready;
  endtask

  task automatic chk_frame(input int start, input int len, input logic [31:0] st, input int id);
    chk("R1 status word", bmem[start / 4], st);
    chk("R1 length word", bmem[((start + 4) % BUF) / 4], 32'(len));
    for (int i = 0; i < (len + 3) / 4; i++)
      chk("R1 payload word", bmem[((start + 8 + 4 * i) % BUF) / 4], pat(id, i));
  endtask

  function automatic int need_of(input int len);
    return 8 + ((len + 3) / 4) * 4;
  endfunction

  initial begin
    finished = 1'b0;
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic r0, r1, r2;
    int start, w0;
    n_chk = 0; n_err = 0; we_cnt = 0; exp_pos = 0;
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_last = 0; in_len = 0;
    in_status = 0; in_data = 0; reg_rd = 0; reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk("R9 in_ready", 32'(in_ready), 32'd1);
    chk("R9 irq", 32'(irq), 32'd0);
    rd(3'd0, v); chk("R9 count", 32'(v), 32'd0);
    rd(3'd1, v); chk("R9 event", 32'(v), 32'd0);
    rd(3'd2, v); chk("R9 config", 32'(v), 32'd0);
    rd(3'd3, v); chk("R9 frame start", 32'(v), 32'd0);
    rd(3'd4, v); chk("R9 write offset", 32'(v), 32'd0);
    rd(3'd0, v); chk("R9 count after phase toggle", 32'(v), 32'd0);

    // Length sweep with interrupt enabled
    wr(3'd2, 16'h0080);
    rd(3'd2, v); chk("R6 config readback", 32'(v), 32'h0080);
    for (int len = 0; len <= 12; len++) begin
      start = exp_pos;
      send(len, len, 32'h5A000000 | 32'(len), r0, r1, r2);
      chk("R10 stall cycle 1", 32'(r0), 32'd0);
      chk("R10 stall cycle 2", 32'(r1), 32'd0);
      chk("R10 ready again", 32'(r2), 32'd1);
      chk("R6 irq raised", 32'(irq), 32'd1);
      exp_pos = (start + need_of(len)) % BUF;
      rd(3'd3, v); chk("R8 frame start", 32'(v), 32'(start));
      rd(3'd4, v); chk("R2 next aligned start", 32'(v), 32'(exp_pos));
      chk_frame(start, len, 32'h5A000000 | 32'(len), len);
      rd(3'd1, v); chk("R7 event frame bit", 32'(v), 32'h0080);
      chk("R7 irq cleared by event read", 32'(irq), 32'd0);
      rd(3'd1, v); chk("R7 event cleared", 32'(v), 32'd0);
    end
    rd(3'd0, v); chk("R3 commit read count", 32'(v), 32'd13);
    rd(3'd0, v); chk("R4 release read count", 32'(v), 32'd0);

    // Fill with interrupt disabled
    wr(3'd2, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      start = exp_pos;
      send(100 + k, 1000, 32'h77000000 | 32'(k), r0, r1, r2);
      if (k == 0) chk("R6 irq masked", 32'(irq), 32'd0);
      exp_pos = (start + 1008) % BUF;
    end
    chk_frame(start, 1000, 32'h77000000 | 32'd15, 115);
    rd(3'd4, v); chk("R2 offset after fill", 32'(v), 32'd16328);

    // 17th frame does not fit: 256 bytes free
    w0 = we_cnt;
    send(116, 1000, 32'h1, r0, r1, r2);
    chk("R10 no stall on drop", 32'(r0 & r1 & r2), 32'd1);
    chk("R5 no write on drop", 32'(we_cnt - w0), 32'd0);
    rd(3'd4, v); chk("R5 offset unchanged", 32'(v), 32'(exp_pos));
    rd(3'd1, v); chk("R5 overrun and frame bits", 32'(v), 32'h0280);
    rd(3'd0, v); chk("R3 commit sixteen", 32'(v), 32'd16);

    // Fits in remaining 256 bytes, wraps around the end
    start = exp_pos;
    send(200, 200, 32'hABCD0001, r0, r1, r2);
    exp_pos = (start + 208) % BUF;
    chk_frame(start, 200, 32'hABCD0001, 200);
    rd(3'd4, v); chk("R2 wrapped offset", 32'(v), 32'd152);

    // Committed space is protected: 48 bytes free
    w0 = we_cnt;
    send(201, 100, 32'h2, r0, r1, r2);
    chk("R5 committed space protected", 32'(we_cnt - w0), 32'd0);
    rd(3'd1, v); chk("R5 overrun after protect", 32'(v), 32'h0280);
    rd(3'd0, v); chk("R4 release keeps count", 32'(v), 32'd1);

    // Released space is reusable
    start = exp_pos;
    send(202, 100, 32'hABCD0002, r0, r1, r2);
    exp_pos = (start + 108) % BUF;
    chk_frame(start, 100, 32'hABCD0002, 202);
    rd(3'd3, v); chk("R8 start after reuse", 32'(v), 32'd152);
    rd(3'd0, v); chk("R3 commit two", 32'(v), 32'd2);
    rd(3'd0, v); chk("R4 release zero", 32'(v), 32'd0);

    // Exact fit of the whole buffer
    start = exp_pos;
    w0 = we_cnt;
    send(300, 16376, 32'hFEED0000, r0, r1, r2);
    chk("R5 exact fit accepted writes", 32'(we_cnt - w0), 32'd4096);
    exp_pos = (start + 16384) % BUF;
    chk_frame(start, 16376, 32'hFEED0000, 300);
    rd(3'd4, v); chk("R2 offset after full frame", 32'(v), 32'(exp_pos));
    w0 = we_cnt;
    send(301, 0, 32'h3, r0, r1, r2);
    chk("R5 full buffer drops empty frame", 32'(we_cnt - w0), 32'd0);
    rd(3'd1, v); chk("R7 both flags", 32'(v), 32'h0280);
    rd(3'd0, v); chk("R3 commit full", 32'(v), 32'd1);
    rd(3'd0, v); chk("R4 release full", 32'(v), 32'd0);
    start = exp_pos;
    send(302, 0, 32'h4, r0, r1, r2);
    chk_frame(start, 0, 32'h4, 302);
    rd(3'd4, v); chk("R2 header-only frame", 32'(v), 32'((start + 8) % BUF));

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule